// File: doc/BRIEF.md
# Down-Spread Clock Frequency Modulator

This block sweeps the frequency of a clock generated by a phase accumulator. The sweep only goes downward, which spreads the clock's radiated energy over a narrow band. It runs on a fast reference clock. It takes a nominal frequency word and an active-low spread request. It produces two results: the frequency word actually applied to the modulated accumulator, and the most significant bit of that accumulator, which serves as the modulated clock. The clocks that feed the host, memory reference, 66 MHz and PCI domains would take the modulated word.

A second accumulator runs from its own word, with no modulation. It stands for the 48 MHz and reference domains, which must stay fixed whatever the spread request does.

The profile is a triangle of `STEPS` levels. The block holds each level for `DWELL` reference cycles. The peak of the triangle is the nominal word, and the trough lies about 0.5% below it, so the mean falls about 0.25% low. The spread request is synchronised. It is only acted on at the peak of the triangle, where the applied word equals the nominal one, so turning spread on or off never causes a step in frequency.

Top module: `ssc_modulator`

## Requirements
- R1: While spread is inactive and the triangle is at rest, `mod_word_o` equals the value `nom_word_i` had one clock earlier.
- R2: While sweeping, `mod_word_o` equals `nom - off(k)`, where `off(k) = floor(depth*k/STEPS)`. The level k moves up from 0 to `STEPS` and back down, changing by exactly one every `DWELL` clocks, and it never leaves the range 0..`STEPS`.
- R3: `depth = floor(nom*41/8192)`, which is about 0.5%. The applied word never exceeds `nom` and never falls below `nom - depth`. Over a sweep it reaches both limits.
- R4: Over one full triangle period of `2*STEPS*DWELL` clocks, the sum of applied words equals `2*STEPS*DWELL*nom - DWELL*(2*sum(off(1..STEPS-1)) + off(STEPS))`. This places the mean about 0.25% below nominal.
- R5: A spread request (`spread_ni` low) starts a sweep only from the top of the triangle. The first applied word that differs from nominal is `nom - off(1)`, and it appears within `DWELL+4` clocks.
- R6: Releasing the request (`spread_ni` high) in the middle of a sweep does not cut the sweep short. The triangle runs back to the top, and from then on the word stays at nominal.
- R7: `fix_clk_o` is the MSB of an accumulator stepped by `fix_word_i` every clock. It is unaffected by `spread_ni`.
- R8: `mod_clk_o` is the MSB of an accumulator stepped by `mod_word_o` every clock.
- R9: In reset, `mod_word_o`, `mod_clk_o` and `fix_clk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_ni | input | 1 | Spread request, active low (tie high for off) |
| nom_word_i | input | W | Nominal frequency word of the modulated path |
| fix_word_i | input | W | Frequency word of the unmodulated path |
| mod_word_o | output | W | Frequency word applied to the modulated accumulator |
| mod_clk_o | output | 1 | Modulated clock (accumulator MSB) |
| fix_clk_o | output | 1 | Unmodulated clock (accumulator MSB) |

## Verification
The bound checks compare the applied word with the nominal word of the previous clock. They therefore assume `nom_word_i` changes only while the sweep is at rest, or at least not while the trough is being compared. The stimulus keeps the nominal word constant for each spread episode. The stimulus also draws nominal words with a high bit set, so that `depth/STEPS` is non-zero and every level of the triangle is visible at the output. Requests are released either at the trough or during idle, so that both the deferred stop and the deferred start are observed.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // down-spread depth = nom * DEPTH_NUM / 2**DEPTH_SH  (~0.5%)
  localparam int unsigned DEPTH_NUM = 41;
  localparam int unsigned DEPTH_SH  = 13;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} tri_dir_e;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic en_o
);
  logic [STAGES-1:0] sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], req_ni};
  end
  assign en_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
  import ssc_pkg::*;
#(
  parameter int unsigned SB    = 6,
  parameter int unsigned DWELL = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  output logic [SB:0] tri_o
);
  localparam int unsigned DW    = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [SB:0] TOP   = (SB+1)'(1 << SB);
  localparam logic [DW-1:0] LAST = DW'(DWELL - 1);

  logic [DW-1:0] dwell_q;
  logic [SB:0]   tri_q;
  tri_dir_e      dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_q <= '0;
      tri_q   <= '0;
      dir_q   <= DIR_DOWN;
    end else if (dwell_q == LAST) begin
      dwell_q <= '0;
      if (tri_q == '0) begin
        // request sampled only at the top (zero offset)
        if (en_i) begin
          tri_q <= (SB+1)'(1);
          dir_q <= DIR_UP;
        end
      end else if (dir_q == DIR_UP) begin
        if (tri_q == TOP) begin
          tri_q <= TOP - (SB+1)'(1);
          dir_q <= DIR_DOWN;
        end else begin
          tri_q <= tri_q + (SB+1)'(1);
        end
      end else begin
        tri_q <= tri_q - (SB+1)'(1);
      end
    end else begin
      dwell_q <= dwell_q + DW'(1);
    end
  end

  assign tri_o = tri_q;
endmodule

// File: rtl/ssc_word_calc.sv
module ssc_word_calc
  import ssc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SB = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] nom_i,
  input  logic [SB:0]  tri_i,
  output logic [W-1:0] word_o
);
  localparam int unsigned PW = W + 8;
  localparam int unsigned OW = W + SB + 1;

  logic [PW-1:0] depth_prod;
  logic [W-1:0]  depth;
  logic [OW-1:0] off_prod;
  logic [W-1:0]  offset;
  logic [W-1:0]  word_q;

  assign depth_prod = PW'(nom_i) * PW'(DEPTH_NUM);
  assign depth      = W'(depth_prod >> DEPTH_SH);
  assign off_prod   = OW'(depth) * OW'(tri_i);
  assign offset     = W'(off_prod >> SB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= nom_i - offset;
  end

  assign word_o = word_q;
endmodule

// File: rtl/ssc_phase_acc.sv
module ssc_phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] inc_i,
  output logic         msb_o
);
  logic [W-1:0] acc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + inc_i;
  end
  assign msb_o = acc_q[W-1];
endmodule

// File: rtl/ssc_modulator.sv
module ssc_modulator #(
  parameter int unsigned W     = 32,
  parameter int unsigned SB    = 6,
  parameter int unsigned DWELL = 100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         spread_ni,
  input  logic [W-1:0] nom_word_i,
  input  logic [W-1:0] fix_word_i,
  output logic [W-1:0] mod_word_o,
  output logic         mod_clk_o,
  output logic         fix_clk_o
);
  logic        en_sync;
  logic [SB:0] tri_cnt;

  ssc_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(spread_ni), .en_o(en_sync)
  );

  ssc_tri_gen #(.SB(SB), .DWELL(DWELL)) u_tri (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_sync), .tri_o(tri_cnt)
  );

  ssc_word_calc #(.W(W), .SB(SB)) u_word (
    .clk_i(clk_i), .rst_ni(rst_ni), .nom_i(nom_word_i), .tri_i(tri_cnt),
    .word_o(mod_word_o)
  );

  ssc_phase_acc #(.W(W)) u_mod_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(mod_word_o), .msb_o(mod_clk_o)
  );

  // unmodulated path for the fixed domains
  ssc_phase_acc #(.W(W)) u_fix_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fix_word_i), .msb_o(fix_clk_o)
  );
endmodule

// File: rtl/ssc_modulator_chk.sv
module ssc_modulator_chk
  import ssc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SB = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_sync,
  input logic [SB:0]  tri_cnt,
  input logic [W-1:0] nom_word_i,
  input logic [W-1:0] mod_word_o
);
  localparam int unsigned PW = W + 8;
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  function automatic logic [W-1:0] depth_f(input logic [W-1:0] n);
    logic [PW-1:0] p;
    p = PW'(n) * PW'(DEPTH_NUM);
    return W'(p >> DEPTH_SH);
  endfunction

  p_idle_nominal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(tri_cnt) == '0 |-> mod_word_o == $past(nom_word_i));

  p_level_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_cnt <= (SB+1)'(1 << SB));

  p_level_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && tri_cnt != $past(tri_cnt) |->
      (tri_cnt == $past(tri_cnt) + (SB+1)'(1)) || (tri_cnt + (SB+1)'(1) == $past(tri_cnt)));

  p_word_bounds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> mod_word_o <= $past(nom_word_i) &&
               mod_word_o >= $past(nom_word_i) - depth_f($past(nom_word_i)));

  p_start_at_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(tri_cnt) == '0 && tri_cnt != '0 |-> $past(en_sync));
endmodule

bind ssc_modulator ssc_modulator_chk #(.W(W), .SB(SB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_sync(en_sync), .tri_cnt(tri_cnt),
  .nom_word_i(nom_word_i), .mod_word_o(mod_word_o)
);

// File: tb/ssc_modulator_tb.sv
`timescale 1ns/1ps
module ssc_modulator_tb;
  localparam int unsigned W = 32, SB = 4, DWELL = 3;
  localparam int unsigned STEPS = 1 << SB;
  localparam int unsigned PERIOD = 2 * STEPS * DWELL;

  logic clk = 0, rst_n = 0, spread_n = 1;
  logic [W-1:0] nom = '0, fix = '0, word;
  logic mclk, fclk;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ssc_modulator #(.W(W), .SB(SB), .DWELL(DWELL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .spread_ni(spread_n), .nom_word_i(nom),
    .fix_word_i(fix), .mod_word_o(word), .mod_clk_o(mclk), .fix_clk_o(fclk)
  );

  function automatic longint unsigned depth_f(longint unsigned n);
    return (n * 41) >> 13;
  endfunction
  function automatic longint unsigned off_f(longint unsigned n, int k);
    return (depth_f(n) * longint'(k)) >> SB;
  endfunction
  function automatic longint unsigned off_sum_f(longint unsigned n);
    longint unsigned s = 0;
    for (int k = 1; k < STEPS; k++) s += 2 * off_f(n, k);
    return DWELL * (s + off_f(n, STEPS));
  endfunction
  function automatic bit on_grid_f(longint unsigned n, longint unsigned w);
    for (int k = 0; k <= STEPS; k++) if (w == n - off_f(n, k)) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    longint unsigned n, mn, mx, sum, exp_sum;
    int edges, fedges, t;
    bit pm, pf, ok;
    void'($urandom(32'h5eed));
    repeat (3) tick();
    chk(word == 0 && mclk == 0 && fclk == 0, "R9", word, 0);
    rst_n = 1;

    // R1: idle word follows nominal, one clock later
    for (int i = 0; i < 6; i++) begin
      nom = $urandom() | 32'h4000_0000;
      tick();
      chk(word == nom, "R1", word, nom);
    end

    // R8 / R7: edge counts with spread off
    nom = 32'h4000_0000; fix = 32'h2000_0000;
    tick(); pm = mclk; pf = fclk; edges = 0; fedges = 0;
    for (int i = 0; i < 800; i++) begin
      tick();
      if (mclk && !pm) edges++;
      if (fclk && !pf) fedges++;
      pm = mclk; pf = fclk;
    end
    chk(edges == 200, "R8 off", edges, 200);
    chk(fedges == 100, "R7 off", fedges, 100);

    // R5/R2/R3 on random nominal words
    for (int ep = 0; ep < 3; ep++) begin
      n = (ep == 0) ? 64'h4000_0000 : 64'($urandom() | 32'h4000_0000);
      nom = W'(n);
      repeat (PERIOD) tick();
      spread_n = 0;
      t = 0;
      while (word == nom && t < 50) begin tick(); t++; end
      chk(word == n - off_f(n, 1), "R5 first step", word, n - off_f(n, 1));
      chk(t <= DWELL + 4, "R5 start latency", t, DWELL + 4);
      mn = word; mx = word; ok = 1;
      for (int i = 0; i < 2 * PERIOD; i++) begin
        tick();
        if (word < mn) mn = word;
        if (word > mx) mx = word;
        if (!on_grid_f(n, word)) ok = 0;
      end
      chk(ok, "R2 levels", word, n);
      chk(mn == n - depth_f(n), "R3 min", mn, n - depth_f(n));
      chk(mx == n, "R3 max", mx, n);
      // R4: sum over one full period
      sum = 0;
      for (int i = 0; i < PERIOD; i++) begin tick(); sum += word; end
      exp_sum = PERIOD * n - off_sum_f(n);
      chk(sum == exp_sum, "R4 mean", sum, exp_sum);
      if (ep == 0) begin
        // R8/R7 under spread
        tick(); pm = mclk; pf = fclk; edges = 0; fedges = 0; sum = 0;
        for (int i = 0; i < 10 * PERIOD; i++) begin
          sum += word;
          tick();
          if (mclk && !pm) edges++;
          if (fclk && !pf) fedges++;
          pm = mclk; pf = fclk;
        end
        chk(fedges == 10 * PERIOD / 8, "R7 on", fedges, 10 * PERIOD / 8);
        chk(edges >= (sum >> 32) - 1 && edges <= (sum >> 32) + 1, "R8 on",
            edges, sum >> 32);
      end
      // R6: release at the trough, sweep must finish
      t = 0;
      while (word != n - depth_f(n) && t < 200) begin tick(); t++; end
      spread_n = 1;
      ok = 1;
      for (int i = 0; i < 40; i++) begin tick(); if (word == nom) ok = 0; end
      chk(ok, "R6 no early stop", word, n - 1);
      t = 0;
      while (word != nom && t < 60) begin tick(); t++; end
      ok = 1;
      for (int i = 0; i < 100; i++) begin tick(); if (word != nom) ok = 0; end
      chk(ok, "R6 hold nominal", word, n);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule